// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a single pulse-width modulation channel built around a down-counter whose width is a parameter (16 bits by default). The counter moves only on cycles where a tick enable is high, so an outside prescaler sets the PWM clock rate while the logic stays on the system clock. Each period starts at a programmed period value and counts down to zero. The output is low after each load and goes high when the count meets a programmed compare value, which sets the duty cycle.

Software writes the period and compare values into staging registers. The values in use change only when the counter is loaded, either at start or at the automatic reload after zero, so a write in the middle of a period never shortens or glitches the current pulse. The channel either reloads and repeats (periodic mode) or halts after one period (one-shot mode). Each time the counter passes through zero, a sticky interrupt flag is set, and software clears it with a write-one strobe.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: While running, the count drops by one on each cycle with tick_i high and holds on cycles without a tick. A period set to P therefore spans P+1 ticks.
- R2: A zero period with a zero compare value gives a constant high output and an interrupt on every tick in periodic mode.
- R3: After each load or reload the output is low until the count equals the active compare value. From that cycle it stays high up to the next reload, so when compare is at most period the output is high exactly while count is at most compare.
- R4: Writes to the period or compare staging registers leave the running period and its output pattern unchanged. The new values first apply at the next load or reload.
- R5: irq_o goes high on the clock edge of every tick taken at count zero and stays high until irq_clr_i is asserted. If a zero tick and a clear happen in the same cycle, the flag ends up set.
- R6: In periodic mode (ctl_oneshot_i = 0) a tick at count zero reloads the count from the period staging register and the active compare value from the compare staging register.
- R7: In one-shot mode (ctl_oneshot_i = 1) a tick at count zero stops the channel. It raises one interrupt, the output then stays low, and later ticks raise no interrupt.
- R8: A compare value greater than the period gives a constant low output for that period.
- R9: A control write with ctl_run_i = 0 stops the channel and drives the output low from the next cycle. It takes priority over a tick in the same cycle.
- R10: A control write with ctl_run_i = 1 while stopped loads both staging registers and starts counting from the period value. The same write while running only updates the mode, which applies from the next cycle.
- R11: After reset the output and the interrupt flag are low, the channel is stopped, both staging registers hold zero and the mode is periodic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle PWM clock enable |
| per_wr_i | input | 1 | Write strobe for the period staging register |
| per_data_i | input | CNT_W | Period value to stage |
| cmp_wr_i | input | 1 | Write strobe for the compare staging register |
| cmp_data_i | input | CNT_W | Compare value to stage |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_run_i | input | 1 | Run bit carried by a control write |
| ctl_oneshot_i | input | 1 | Mode bit carried by a control write: 1 one-shot, 0 periodic |
| irq_clr_i | input | 1 | Write-one strobe that clears the interrupt flag |
| pwm_o | output | 1 | PWM output level |
| irq_o | output | 1 | Sticky interrupt flag set at each zero tick |

## Verification
The assertions assume that rst_n is low at time zero and stays low until the clock is running. They also assume every input is a known level at each rising edge. They make no assumption about how often tick_i is high. The stimulus changes inputs just after a rising edge and pulls every strobe back low after one cycle. It mixes dense and sparse ticks, and it never sends a mode-only control write in the same cycle as a zero tick. This keeps the cases where one input could take priority over another limited to the ones the requirements define.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   typedef enum logic {
      MODE_PERIODIC = 1'b0,
      MODE_ONESHOT  = 1'b1
   } pwm_mode_e;

   localparam int PER_SLOT = 0;
   localparam int CMP_SLOT = 1;
   localparam int N_SLOTS  = 2;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             per_wr_i,
   input  logic [CNT_W-1:0] per_data_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_data_i,
   input  logic             load_i,
   output logic [CNT_W-1:0] per_stage_o,
   output logic [CNT_W-1:0] cmp_act_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_shadow_regs: CNT_W must be at least 2");
   end

   logic [N_SLOTS-1:0]            wr_en;
   logic [N_SLOTS-1:0][CNT_W-1:0] wr_data;
   logic [N_SLOTS-1:0][CNT_W-1:0] stage_q;
   logic [CNT_W-1:0]              cmp_act_q;

   assign wr_en[PER_SLOT]   = per_wr_i;
   assign wr_en[CMP_SLOT]   = cmp_wr_i;
   assign wr_data[PER_SLOT] = per_data_i;
   assign wr_data[CMP_SLOT] = cmp_data_i;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        stage_q[s] <= '0;
         else if (wr_en[s]) stage_q[s] <= wr_data[s];
      end
      // the period's live copy is the counter itself; only compare needs one
      if (s == CMP_SLOT) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cmp_act_q <= '0;
            else if (load_i) cmp_act_q <= stage_q[s];
         end
      end
   end

   assign per_stage_o = stage_q[PER_SLOT];
   assign cmp_act_o   = cmp_act_q;

   AST_CMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(cmp_act_q)); // R4
   AST_CMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cmp_act_q == $past(stage_q[CMP_SLOT])); // R6
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  pwm_mode_e        mode_i,
   input  logic [CNT_W-1:0] reload_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             zero_evt_o,
   output logic             reload_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_down_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             at_zero;
   logic             step;

   assign at_zero    = (cnt_q == '0);
   assign step       = run_q & tick_i & ~stop_i;
   assign zero_evt_o = step & at_zero;
   assign reload_o   = zero_evt_o & (mode_i == MODE_PERIODIC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start_i) begin
         cnt_q <= reload_val_i;
         run_q <= 1'b1;
      end else if (stop_i) begin
         run_q <= 1'b0;
      end else if (step) begin
         if (!at_zero)      cnt_q <= cnt_q - 1'b1;
         else if (reload_o) cnt_q <= reload_val_i;
         else               run_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;
   assign run_o = run_q;

   AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && !stop_i && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start_i) |=> $stable(cnt_q)); // R1
   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt_o && mode_i == MODE_ONESHOT) |=> !run_q); // R7
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      reload_o |=> (run_q && cnt_q == $past(reload_val_i))); // R6
endmodule

// File: rtl/pwm_level_gen.sv
module pwm_level_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             pwm_o
);
   logic hit_q;
   logic hit_now;

   assign hit_now = (cnt_i == cmp_i);

   // once the count meets compare the level latches high until the next load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hit_q <= 1'b0;
      else if (load_i || !run_i)   hit_q <= 1'b0;
      else if (hit_now)            hit_q <= 1'b1;
   end

   assign pwm_o = run_i & (hit_q | hit_now);

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && pwm_o && !load_i) |=> (pwm_o || !run_i)); // R3
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             per_wr_i,
   input  logic [CNT_W-1:0] per_data_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_data_i,
   input  logic             ctl_wr_i,
   input  logic             ctl_run_i,
   input  logic             ctl_oneshot_i,
   input  logic             irq_clr_i,
   output logic             pwm_o,
   output logic             irq_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_dbuf_channel: CNT_W must lie in 2..32");
   end

   pwm_mode_e        mode_q;
   logic             run;
   logic             start;
   logic             stop;
   logic             zero_evt;
   logic             reload;
   logic             load;
   logic             irq_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per_stage;
   logic [CNT_W-1:0] cmp_act;

   assign start = ctl_wr_i & ctl_run_i & ~run;
   assign stop  = ctl_wr_i & ~ctl_run_i;
   assign load  = start | reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= MODE_PERIODIC;
      else if (ctl_wr_i) mode_q <= ctl_oneshot_i ? MODE_ONESHOT : MODE_PERIODIC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (zero_evt)  irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
   end
   assign irq_o = irq_q;

   pwm_shadow_regs #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .per_wr_i(per_wr_i), .per_data_i(per_data_i),
      .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
      .load_i(load), .per_stage_o(per_stage), .cmp_act_o(cmp_act));

   pwm_down_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .start_i(start), .stop_i(stop), .mode_i(mode_q),
      .reload_val_i(per_stage), .cnt_o(cnt), .run_o(run),
      .zero_evt_o(zero_evt), .reload_o(reload));

   pwm_level_gen #(.CNT_W(CNT_W)) u_level (
      .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load),
      .cnt_i(cnt), .cmp_i(cmp_act), .pwm_o(pwm_o));

   AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> irq_o); // R5
   AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !pwm_o); // R9
   AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (load && per_stage != '0 && cnt == '0) |=> (run && cnt != '0)); // R10
endmodule

// File: tb/sim_pwm_dbuf_channel.sv
module sim_pwm_dbuf_channel;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b0;
   logic         per_wr_i = 1'b0;
   logic [W-1:0] per_data_i = '0;
   logic         cmp_wr_i = 1'b0;
   logic [W-1:0] cmp_data_i = '0;
   logic         ctl_wr_i = 1'b0;
   logic         ctl_run_i = 1'b0;
   logic         ctl_oneshot_i = 1'b0;
   logic         irq_clr_i = 1'b0;
   logic         pwm_o;
   logic         irq_o;

   pwm_dbuf_channel #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .per_wr_i(per_wr_i), .per_data_i(per_data_i),
      .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
      .ctl_wr_i(ctl_wr_i), .ctl_run_i(ctl_run_i), .ctl_oneshot_i(ctl_oneshot_i),
      .irq_clr_i(irq_clr_i), .pwm_o(pwm_o), .irq_o(irq_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   bit    exp_pwm_q[$];
   bit    exp_irq_q[$];
   string req_q[$];

   // behavioural model of the requirements
   bit         m_run = 0, m_os = 0, m_irq = 0;
   logic [W-1:0] m_cnt = '0, m_per = '0, m_cmp = '0, m_sper = '0, m_scmp = '0;

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (exp_pwm_q.size() > 0) begin
         automatic bit    ep = exp_pwm_q.pop_front();
         automatic bit    ei = exp_irq_q.pop_front();
         automatic string rq = req_q.pop_front();
         chk(rq, "pwm_o", pwm_o, ep);
         chk(rq, "irq_o", irq_o, ei);
      end
   end

   task automatic cyc(input bit tk, input bit pw, input logic [W-1:0] pd,
                      input bit cw, input logic [W-1:0] cd,
                      input bit ctw, input bit crun, input bit cos,
                      input bit clr, input string req);
      bit start_m, stop_m, zero, os_old;
      logic [W-1:0] sp, sc;
      tick_i = tk; per_wr_i = pw; per_data_i = pd; cmp_wr_i = cw; cmp_data_i = cd;
      ctl_wr_i = ctw; ctl_run_i = crun; ctl_oneshot_i = cos; irq_clr_i = clr;
      @(posedge clk);
      #1;
      start_m = ctw && crun && !m_run;
      stop_m  = ctw && !crun;
      zero = 0; os_old = m_os; sp = m_sper; sc = m_scmp;
      if (start_m) begin
         m_per = sp; m_cmp = sc; m_cnt = sp; m_run = 1;
      end else if (stop_m) begin
         m_run = 0;
      end else if (m_run && tk) begin
         if (m_cnt == 0) begin
            zero = 1;
            if (os_old) m_run = 0;
            else begin m_per = sp; m_cmp = sc; m_cnt = sp; end
         end else m_cnt = m_cnt - 1'b1;
      end
      if (ctw) m_os = cos;
      if (zero) m_irq = 1;
      else if (clr) m_irq = 0;
      if (pw) m_sper = pd;
      if (cw) m_scmp = cd;
      exp_pwm_q.push_back(m_run && (m_cmp <= m_per) && (m_cnt <= m_cmp));
      exp_irq_q.push_back(m_irq);
      req_q.push_back(req);
      tick_i = 0; per_wr_i = 0; cmp_wr_i = 0; ctl_wr_i = 0; irq_clr_i = 0;
   endtask

   task automatic ticks(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(1, 0, '0, 0, '0, 0, 0, 0, 0, req);
   endtask
   task automatic wr_per(input logic [W-1:0] v, input string req);
      cyc(0, 1, v, 0, '0, 0, 0, 0, 0, req);
   endtask
   task automatic wr_cmp(input logic [W-1:0] v, input string req);
      cyc(0, 0, '0, 1, v, 0, 0, 0, 0, req);
   endtask
   task automatic ctl(input bit run, input bit os, input string req);
      cyc(0, 0, '0, 0, '0, 1, run, os, 0, req);
   endtask
   task automatic clr(input string req);
      cyc(0, 0, '0, 0, '0, 0, 0, 0, 1, req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "pwm_o after reset", pwm_o, 1'b0);
      chk("R11", "irq_o after reset", irq_o, 1'b0);
      @(posedge clk); #1;

      // staging writes alone do not start the channel
      wr_per(16'd4, "R4");
      wr_cmp(16'd2, "R4");
      ticks(3, "R11");
      ctl(1, 0, "R10");
      ticks(12, "R3");
      ticks(10, "R6");
      clr("R5");

      // stage new values mid-period: current period unaffected
      wr_per(16'd6, "R4");
      ticks(1, "R4");
      wr_cmp(16'd1, "R4");
      ticks(16, "R4");

      // sparse ticks: count holds between ticks
      for (int i = 0; i < 12; i++) begin
         cyc(1, 0, '0, 0, '0, 0, 0, 0, 0, "R1");
         cyc(0, 0, '0, 0, '0, 0, 0, 0, 0, "R1");
         cyc(0, 0, '0, 0, '0, 0, 0, 0, 0, "R1");
      end

      // mode change while running, then one-shot completes
      ctl(1, 1, "R10");
      ticks(12, "R7");
      clr("R7");
      ticks(6, "R7");

      // restart periodic, stop in mid-period and against a tick
      ctl(1, 0, "R10");
      ticks(3, "R9");
      cyc(1, 0, '0, 0, '0, 1, 0, 0, 0, "R9");
      ticks(4, "R9");

      // compare above period
      wr_per(16'd3, "R8");
      wr_cmp(16'd9, "R8");
      ctl(1, 0, "R8");
      ticks(10, "R8");
      ctl(0, 0, "R8");

      // zero period and zero compare
      wr_per(16'd0, "R2");
      wr_cmp(16'd0, "R2");
      ctl(1, 0, "R2");
      ticks(5, "R2");
      ctl(0, 0, "R2");

      // clear strobed on every tick: set wins at the zero tick
      wr_per(16'd2, "R5");
      wr_cmp(16'd1, "R5");
      ctl(1, 0, "R5");
      for (int i = 0; i < 9; i++) cyc(1, 0, '0, 0, '0, 0, 0, 0, 1, "R5");
      clr("R5");
      ticks(2, "R5");

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule